// File: doc/BRIEF.md
# Framebuffer Scanout Address Sequencer

This block walks a linear framebuffer in memory and produces the burst read requests that bring one display frame into a pixel FIFO. Software programs a frame start address and an end address. The start address may already include a pan offset of y rows times the pitch plus x pixels times the bytes per pixel. The end address is the start address plus the line count times the line pitch. Software also picks a burst length of 1, 2, 4, 8 or 16 words. While raster output is enabled, the sequencer issues word-aligned bursts from the start address towards the end address. It clips the final burst so that it stops exactly at the end address. It then wraps back to the start address for the next frame.

Requests go out on a valid/ready channel. A new request is raised only while the FIFO fill level is below a programmable threshold. Once raised, a request keeps its address and word count until memory accepts it, even if the fill level rises in the meantime. Address writes made while a frame is running land in shadow registers and take effect at the next frame boundary. Clearing the raster enable lets the running frame finish, and a frame-done pulse follows one cycle after its last burst. Three sticky status bits record end of frame, frame done and pixel-side underflow. Each bit is cleared by writing one to it, and an enable mask selects which bits drive the interrupt line.

Top module: `fbscan_seq`

## Requirements
- R1: After reset, req_valid, eof_pulse, done_pulse, sts and irq are all 0, and the burst length is MAX_BURST (16).
- R2: A write of 1, 2, 4, 8 or 16 to the burst length takes effect, and every burst that is not the last one of a frame requests exactly that many words (req_words is the binary word count).
- R3: A burst length write of any other value (for example 0 or 12) is ignored, and the previous length stays in force.
- R4: A frame's first request is at the start address, and each accepted burst advances the next request address by burst length times 4 bytes.
- R5: The last burst of a frame requests (end − address)/4 words when that is no more than the burst length, and eof_pulse is high in exactly the cycle that this burst is accepted.
- R6: After the last burst of a frame is accepted, with raster enable still set, the next request is at the frame start address again.
- R7: Start and end addresses written while a frame runs do not change that frame; they apply from the frame that follows the next end of frame.
- R8: When no request is pending, req_valid rises only while fifo_level < fifo_thr.
- R9: While req_valid is high and req_ready is low, req_valid, req_addr and req_words hold their values in the next cycle, whatever the fill level does.
- R10: If raster enable is low when the last burst of a frame is accepted, the earlier bursts of that frame are all still issued, done_pulse is high for one cycle on the next cycle, and no further request is made until raster enable is set again.
- R11: A pixel read (pix_rd) while fifo_empty is high sets status bit 2, which then stays set. A pixel read with fifo_empty low does not set it.
- R12: Status bit 0 records end of frame and bit 1 records frame done. Writing 1 to a bit in sts_clr clears that bit. irq is high exactly when a status bit and its irq_en bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raster_en | input | 1 | Run scanout; clearing it stops after the current frame |
| base_we | input | 1 | Write strobe for the shadow start address |
| base_wdata | input | AW | Frame start address in bytes, pan offset included, word aligned |
| ceil_we | input | 1 | Write strobe for the shadow end address |
| ceil_wdata | input | AW | Frame end address in bytes (exclusive), word aligned |
| blen_we | input | 1 | Write strobe for the burst length |
| blen_wdata | input | clog2(MAX_BURST)+1 | Requested burst length in words |
| fifo_thr | input | FW | Fill level below which a new burst is requested |
| fifo_level | input | FW | Current pixel FIFO fill level |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| pix_rd | input | 1 | Pixel side reads the FIFO this cycle |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Burst start address in bytes |
| req_words | output | clog2(MAX_BURST)+1 | Words in this burst |
| eof_pulse | output | 1 | Last burst of the frame accepted this cycle |
| done_pulse | output | 1 | Scanout has stopped after the final frame |
| sts_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| irq_en | input | 3 | Interrupt enable mask for the status bits |
| sts | output | 3 | Sticky status: bit 0 end of frame, bit 1 frame done, bit 2 underflow |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the programmed end address is above the start address and that both are multiples of 4 bytes. Under that assumption every request carries between 1 and MAX_BURST words, and every frame ends on an exact clip. They also assume that fifo_thr does not change while a request is rising. The rise of req_valid is checked against it. The stimulus programs only word-aligned ranges with the end above the start. It covers ranges that divide evenly into bursts and ranges that need a clipped final burst. It changes fifo_thr only while no request is pending, and it holds back req_ready only in the deliberate stall test.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  localparam int STS_EOF  = 0;
  localparam int STS_DONE = 1;
  localparam int STS_UFL  = 2;
  localparam int NSTS     = 3;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_FIN  = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs #(
  parameter int AW        = 32,
  parameter int MAX_BURST = 16,
  parameter int BW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          ceil_we,
  input  logic [AW-1:0] ceil_wdata,
  input  logic          blen_we,
  input  logic [BW-1:0] blen_wdata,
  input  logic          load_act,
  output logic [AW-1:0] shd_base,
  output logic [AW-1:0] act_ceil,
  output logic [BW-1:0] blen
);
  logic [AW-1:0] shd_ceil_q;

  // a legal length is a non-zero power of two no larger than MAX_BURST
  function automatic logic blen_ok(input logic [BW-1:0] v);
    return (v != '0) && ((v & (v - BW'(1))) == '0) && (v <= BW'(MAX_BURST));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_base   <= '0;
      shd_ceil_q <= '0;
      act_ceil   <= '0;
      blen       <= BW'(MAX_BURST);
    end else begin
      if (base_we) shd_base   <= base_wdata;
      if (ceil_we) shd_ceil_q <= ceil_wdata;
      if (load_act) act_ceil  <= shd_ceil_q;
      if (blen_we && blen_ok(blen_wdata)) blen <= blen_wdata;
    end
  end
endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch import fbscan_pkg::*; #(
  parameter int AW = 32,
  parameter int FW = 6,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raster_en,
  input  logic [AW-1:0] shd_base,
  input  logic [AW-1:0] act_ceil,
  input  logic [BW-1:0] blen,
  input  logic [FW-1:0] fifo_level,
  input  logic [FW-1:0] fifo_thr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_words,
  output logic          eof_pulse,
  output logic          done_pulse,
  output logic          load_act
);
  fetch_st_e     state_q;
  logic [AW-1:0] addr_q;
  logic          hold_q;
  logic [AW-1:0] rem_words;
  logic          is_last;
  logic          hs;

  always_comb begin
    rem_words  = (act_ceil - addr_q) >> 2;
    is_last    = rem_words <= AW'(blen);
    req_words  = is_last ? rem_words[BW-1:0] : blen;
    req_addr   = addr_q;
    req_valid  = (state_q == FS_RUN) && (hold_q || (fifo_level < fifo_thr));
    hs         = req_valid && req_ready;
    eof_pulse  = hs && is_last;
    load_act   = (state_q == FS_IDLE) || eof_pulse;
    done_pulse = (state_q == FS_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      hold_q  <= 1'b0;
    end else begin
      hold_q <= req_valid && !req_ready;
      unique case (state_q)
        FS_IDLE: if (raster_en) begin
          state_q <= FS_RUN;
          addr_q  <= shd_base;
        end
        FS_RUN: if (hs) begin
          if (is_last) begin
            addr_q <= shd_base;
            if (!raster_en) state_q <= FS_FIN;
          end else begin
            addr_q <= addr_q + AW'({blen, 2'b00});
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbscan_status.sv
module fbscan_status import fbscan_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTS-1:0] set,
  input  logic [NSTS-1:0] clr,
  input  logic [NSTS-1:0] en,
  output logic [NSTS-1:0] sts,
  output logic            irq
);
  // a new event wins over a clear in the same cycle
  for (genvar i = 0; i < NSTS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (set[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end
  end

  assign irq = |(sts & en);
endmodule

// File: rtl/fbscan_seq.sv
module fbscan_seq import fbscan_pkg::*; #(
  parameter int AW        = 32,
  parameter int FW        = 6,
  parameter int MAX_BURST = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        raster_en,
  input  logic                        base_we,
  input  logic [AW-1:0]               base_wdata,
  input  logic                        ceil_we,
  input  logic [AW-1:0]               ceil_wdata,
  input  logic                        blen_we,
  input  logic [$clog2(MAX_BURST):0]  blen_wdata,
  input  logic [FW-1:0]               fifo_thr,
  input  logic [FW-1:0]               fifo_level,
  input  logic                        fifo_empty,
  input  logic                        pix_rd,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [AW-1:0]               req_addr,
  output logic [$clog2(MAX_BURST):0]  req_words,
  output logic                        eof_pulse,
  output logic                        done_pulse,
  input  logic [NSTS-1:0]             sts_clr,
  input  logic [NSTS-1:0]             irq_en,
  output logic [NSTS-1:0]             sts,
  output logic                        irq
);
  localparam int BW = $clog2(MAX_BURST) + 1;

  logic [AW-1:0]   shd_base;
  logic [AW-1:0]   act_ceil;
  logic [BW-1:0]   blen;
  logic            load_act;
  logic [NSTS-1:0] sts_set;

  fbscan_regs #(.AW(AW), .MAX_BURST(MAX_BURST), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .ceil_we(ceil_we), .ceil_wdata(ceil_wdata),
    .blen_we(blen_we), .blen_wdata(blen_wdata),
    .load_act(load_act),
    .shd_base(shd_base), .act_ceil(act_ceil), .blen(blen)
  );

  fbscan_fetch #(.AW(AW), .FW(FW), .BW(BW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en),
    .shd_base(shd_base), .act_ceil(act_ceil), .blen(blen),
    .fifo_level(fifo_level), .fifo_thr(fifo_thr),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words),
    .eof_pulse(eof_pulse), .done_pulse(done_pulse), .load_act(load_act)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_EOF]  = eof_pulse;
    sts_set[STS_DONE] = done_pulse;
    sts_set[STS_UFL]  = pix_rd && fifo_empty;
  end

  fbscan_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set(sts_set), .clr(sts_clr), .en(irq_en),
    .sts(sts), .irq(irq)
  );
endmodule

// File: rtl/fbscan_seq_chk.sv
module fbscan_seq_chk #(
  parameter int AW        = 32,
  parameter int FW        = 6,
  parameter int MAX_BURST = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [AW-1:0]              req_addr,
  input logic [$clog2(MAX_BURST):0] req_words,
  input logic                       eof_pulse,
  input logic                       done_pulse,
  input logic [FW-1:0]              fifo_level,
  input logic [FW-1:0]              fifo_thr,
  input logic                       pix_rd,
  input logic                       fifo_empty,
  input logic [2:0]                 sts,
  input logic [2:0]                 sts_clr
);
  localparam int BW = $clog2(MAX_BURST) + 1;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_words))); // R9

  AST_WORDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_words != '0 && req_words <= BW'(MAX_BURST))); // R5

  AST_EOF_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> (req_valid && req_ready)); // R5

  AST_DONE_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(eof_pulse)); // R10

  AST_RISE_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (fifo_level < fifo_thr)); // R8

  AST_UFL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_rd && fifo_empty) |=> sts[2]); // R11

  AST_UFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[2] && !sts_clr[2]) |=> sts[2]); // R11
endmodule

bind fbscan_seq fbscan_seq_chk #(.AW(AW), .FW(FW), .MAX_BURST(MAX_BURST)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_words(req_words),
  .eof_pulse(eof_pulse), .done_pulse(done_pulse),
  .fifo_level(fifo_level), .fifo_thr(fifo_thr),
  .pix_rd(pix_rd), .fifo_empty(fifo_empty),
  .sts(sts), .sts_clr(sts_clr)
);

// File: tb/fbscan_seq_bench.sv
module fbscan_seq_bench;
  localparam int AW = 32;
  localparam int FW = 6;
  localparam int MB = 16;
  localparam int BW = 5;
  localparam int NV = 5;

  // vectors: start, end, burst length -> expected burst count
  localparam logic [31:0] VBASE [0:NV-1] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5004};
  localparam logic [31:0] VCEIL [0:NV-1] = '{32'h1040, 32'h2064, 32'h3018, 32'h400C, 32'h5024};
  localparam logic [4:0]  VBLEN [0:NV-1] = '{5'd16, 5'd8, 5'd4, 5'd1, 5'd2};
  localparam int          VNB   [0:NV-1] = '{1, 4, 2, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raster_en = 1'b0;
  logic base_we = 1'b0, ceil_we = 1'b0, blen_we = 1'b0;
  logic [AW-1:0] base_wdata = '0, ceil_wdata = '0;
  logic [BW-1:0] blen_wdata = '0;
  logic [FW-1:0] fifo_thr = 6'd4, fifo_level = '0;
  logic fifo_empty = 1'b0, pix_rd = 1'b0;
  logic req_valid, req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_words;
  logic eof_pulse, done_pulse;
  logic [2:0] sts_clr = '0, irq_en = '0, sts;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] a;
  logic [31:0] expw;
  logic        last;
  int          nb;

  always #5 clk = ~clk;

  fbscan_seq #(.AW(AW), .FW(FW), .MAX_BURST(MB)) u_fbscan_seq (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en),
    .base_we(base_we), .base_wdata(base_wdata),
    .ceil_we(ceil_we), .ceil_wdata(ceil_wdata),
    .blen_we(blen_we), .blen_wdata(blen_wdata),
    .fifo_thr(fifo_thr), .fifo_level(fifo_level),
    .fifo_empty(fifo_empty), .pix_rd(pix_rd),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words),
    .eof_pulse(eof_pulse), .done_pulse(done_pulse),
    .sts_clr(sts_clr), .irq_en(irq_en), .sts(sts), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=0x1 expected=0x0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!req_valid && !eof_pulse && !done_pulse, "R1 outputs idle", {29'd0, req_valid, eof_pulse, done_pulse}, 0);
    chk(sts == 3'b000 && !irq, "R1 status clear", {28'd0, irq, sts}, 0);

    // table walk: each vector runs one frame, raster enable dropped right after start (R2 R4 R5 R10)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      base_we = 1'b1; base_wdata = VBASE[v];
      ceil_we = 1'b1; ceil_wdata = VCEIL[v];
      blen_we = 1'b1; blen_wdata = VBLEN[v];
      @(negedge clk);
      base_we = 1'b0; ceil_we = 1'b0; blen_we = 1'b0;
      raster_en = 1'b1;
      @(negedge clk);
      raster_en = 1'b0;
      a = VBASE[v];
      nb = 0;
      for (int k = 0; k < 64; k++) begin
        #1;
        last = ((VCEIL[v] - a) >> 2) <= 32'(VBLEN[v]);
        expw = last ? ((VCEIL[v] - a) >> 2) : 32'(VBLEN[v]);
        chk(req_valid && req_addr == a, "R4 burst address", req_addr, a);
        chk(32'(req_words) == expw, "R2 R5 burst words", 32'(req_words), expw);
        chk(eof_pulse == last, "R5 end of frame flag", {31'd0, eof_pulse}, {31'd0, last});
        nb++;
        if (last) break;
        a = a + 32'(VBLEN[v]) * 4;
        @(negedge clk);
      end
      chk(nb == VNB[v], "R2 burst count", nb, VNB[v]);
      step();
      chk(done_pulse, "R10 done after final frame", {31'd0, done_pulse}, 1);
      step();
      chk(!req_valid && !done_pulse, "R10 idle after stop", {30'd0, req_valid, done_pulse}, 0);
    end

    // R3 illegal burst lengths ignored
    @(negedge clk);
    blen_we = 1'b1; blen_wdata = 5'd8;
    @(negedge clk); blen_wdata = 5'd12;
    @(negedge clk); blen_wdata = 5'd0;
    base_we = 1'b1; base_wdata = 32'h100;
    ceil_we = 1'b1; ceil_wdata = 32'h140;
    @(negedge clk);
    blen_we = 1'b0; base_we = 1'b0; ceil_we = 1'b0;
    raster_en = 1'b1;
    @(negedge clk);
    raster_en = 1'b0;
    #1;
    chk(req_valid && req_words == 5'd8, "R3 illegal length ignored", 32'(req_words), 8);
    for (int k = 0; k < 20; k++) begin
      step();
      if (done_pulse) break;
    end

    // continuous run: wrap, shadow, threshold, stall
    @(negedge clk);
    blen_we = 1'b1; blen_wdata = 5'd4;
    base_we = 1'b1; base_wdata = 32'h8000;
    ceil_we = 1'b1; ceil_wdata = 32'h8020;
    @(negedge clk);
    blen_we = 1'b0; base_we = 1'b0; ceil_we = 1'b0;
    raster_en = 1'b1;
    step();
    chk(req_valid && req_addr == 32'h8000 && !eof_pulse, "R4 first burst", req_addr, 32'h8000);
    step();
    chk(req_addr == 32'h8010 && eof_pulse, "R5 second burst ends frame", req_addr, 32'h8010);
    step();
    chk(req_valid && req_addr == 32'h8000, "R6 wrap to start", req_addr, 32'h8000);
    base_we = 1'b1; base_wdata = 32'h9000;
    ceil_we = 1'b1; ceil_wdata = 32'h9010;
    step();
    base_we = 1'b0; ceil_we = 1'b0;
    chk(req_addr == 32'h8010 && eof_pulse, "R7 running frame unchanged", req_addr, 32'h8010);
    step();
    chk(req_addr == 32'h9000 && req_words == 5'd4 && eof_pulse, "R7 new range next frame", req_addr, 32'h9000);
    @(negedge clk);
    fifo_level = 6'd4;
    #1;
    chk(!req_valid, "R8 no request at threshold", {31'd0, req_valid}, 0);
    @(negedge clk);
    fifo_level = 6'd3;
    req_ready = 1'b0;
    #1;
    chk(req_valid, "R8 request below threshold", {31'd0, req_valid}, 1);
    @(negedge clk);
    fifo_level = 6'd10;
    #1;
    chk(req_valid && req_addr == 32'h9000 && req_words == 5'd4, "R9 request held while stalled", req_addr, 32'h9000);
    req_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(!req_valid, "R9 released after accept", {31'd0, req_valid}, 0);
    raster_en = 1'b0;
    @(negedge clk);
    fifo_level = 6'd0;
    #1;
    chk(req_valid && eof_pulse, "R10 final frame completes", {30'd0, req_valid, eof_pulse}, 3);
    step();
    chk(done_pulse, "R10 done pulse", {31'd0, done_pulse}, 1);
    step();
    chk(!req_valid, "R10 no request after done", {31'd0, req_valid}, 0);

    // R11 underflow sticky
    @(negedge clk);
    pix_rd = 1'b1; fifo_empty = 1'b0;
    step();
    chk(sts[2] == 1'b0, "R11 read with data no flag", {31'd0, sts[2]}, 0);
    fifo_empty = 1'b1;
    @(negedge clk);
    pix_rd = 1'b0; fifo_empty = 1'b0;
    #1;
    chk(sts[2], "R11 underflow flagged", {31'd0, sts[2]}, 1);
    step();
    chk(sts[2], "R11 underflow sticky", {31'd0, sts[2]}, 1);

    // R12 mask and write-one-to-clear
    irq_en = 3'b000;
    #1;
    chk(sts == 3'b111 && !irq, "R12 masked irq", {28'd0, irq, sts}, 32'h7);
    irq_en = 3'b100;
    #1;
    chk(irq, "R12 enabled irq", {31'd0, irq}, 1);
    @(negedge clk);
    sts_clr = 3'b100;
    @(negedge clk);
    sts_clr = 3'b000;
    #1;
    chk(sts == 3'b011 && !irq, "R12 clear one bit", {28'd0, irq, sts}, 32'h3);
    irq_en = 3'b001;
    #1;
    chk(irq, "R12 eof bit drives irq", {31'd0, irq}, 1);
    @(negedge clk);
    sts_clr = 3'b011;
    @(negedge clk);
    sts_clr = 3'b000;
    #1;
    chk(sts == 3'b000 && !irq, "R12 clear all", {28'd0, irq, sts}, 0);

    finish_run();
  end
endmodule